// File: doc/BRIEF.md
# Stop-Triggered Circular Capture Buffer

This block records a continuous stream of 16-bit data words into a 2048-entry ring memory. While it is armed, every valid word overwrites the oldest slot, so the memory always holds the most recent history of the stream. A fill count tracks how many of the slots hold valid data, so a buffer that has not yet wrapped is handled as correctly as a full one.

An asynchronous stop input is brought into the data clock domain by a two-flop synchronizer. Its rising edge freezes the ring: no further words are stored, and a status bit is raised for the host to poll. The host then pulls words out one per read strobe. Readout starts at the oldest retained word and moves forward in arrival order. A single clear strobe drops the status bit, empties the ring and re-arms capture.

The host port is a plain strobe interface in the data clock domain. Read data is returned from a registered block-RAM port one cycle after the strobe.

Top module: `stop_capture_ring`

## Requirements
- R1: After a synchronous reset, `status_ready` is 0, `fill_level` is 0, `host_rd_valid` is 0 and the block is armed.
- R2: While armed, each cycle with `in_valid` high stores `in_data`. `fill_level` rises by one per stored word and saturates at 2048, so the ring keeps the last 2048 words.
- R3: `stop_in` passes through two synchronizing flops, and only its rising edge acts. `status_ready` goes to 1 at the third rising clock edge after `stop_in` rises. A level that is held high does not trigger a new freeze after a clear.
- R4: While frozen, words presented on `in_valid`/`in_data` are not stored, and `fill_level` does not change.
- R5: The first word read after a freeze is the oldest retained word. When fewer than 2048 words were stored, this is the first word stored after arming. Otherwise it is the word stored 2048 words before the freeze.
- R6: Each `host_rd_en` pulse while frozen returns one word on `host_rd_data`, with `host_rd_valid` high on the following cycle. Words come out in arrival order, and the read pointer wraps modulo 2048, so read 2049 of a full ring returns the oldest word again.
- R7: `host_rd_en` while armed is ignored, and `host_rd_valid` stays 0.
- R8: A `host_clr` pulse clears `status_ready` and `fill_level`, resets both pointers and re-arms capture. The next capture starts with an empty history.
- R9: A stop rising edge while already frozen has no effect. Readout continues from where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming word qualifier |
| in_data | input | 16 | Incoming data word |
| stop_in | input | 1 | Asynchronous stop request, rising edge acts |
| host_rd_en | input | 1 | Host read strobe, one word per pulse |
| host_clr | input | 1 | Host clear of the status bit, re-arms capture |
| host_rd_data | output | 16 | Word returned by the last read |
| host_rd_valid | output | 1 | High one cycle after an accepted read |
| status_ready | output | 1 | Captured history ready to read |
| fill_level | output | 12 | Number of valid words held, 0 to 2048 |

## Verification
The bench goes after the point where the ring wraps. If the start pointer is chosen wrongly for a partial or exactly full ring, the first word read back is a stale slot or a word from the middle of the history instead of the oldest word. It feeds words while frozen, re-pulses stop in the middle of a readout and holds stop high across a clear. A design that kept writing, re-seeded the read pointer, or triggered on level rather than edge would then return wrong words or an early status bit. It also reads one word past a full ring, which catches a read pointer that saturates instead of wrapping.

// File: rtl/stop_ring_pkg.sv
package stop_ring_pkg;

  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_FROZEN = 1'b1
  } ring_state_e;

  // advance a ring index with explicit wrap so non-power-of-two depths work
  function automatic int unsigned ring_step(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/stop_edge_sync.sv
module stop_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import stop_ring_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              stop_rise,
  input  logic              host_rd_en,
  input  logic              host_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              mem_re,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              frozen,
  output logic [FILL_W-1:0] fill,
  output logic              rd_valid
);

  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

  ring_state_e state;
  logic        full;

  assign frozen = (state == ST_FROZEN);
  assign full   = (fill == FULL);
  assign mem_we = (state == ST_ARMED) && in_valid && !stop_rise && !host_clr;
  assign mem_re = frozen && host_rd_en;

  always_ff @(posedge clk) begin
    if (rst || host_clr) begin
      state  <= ST_ARMED;
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (stop_rise) begin
            state  <= ST_FROZEN;
            rd_ptr <= full ? wr_ptr : '0;
          end else if (in_valid) begin
            wr_ptr <= ADDR_W'(ring_step(int'(wr_ptr), DEPTH));
            if (!full) fill <= fill + 1'b1;
          end
        end
        default: begin
          if (host_rd_en) rd_ptr <= ADDR_W'(ring_step(int'(rd_ptr), DEPTH));
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= mem_re;
  end

endmodule

// File: rtl/stop_capture_ring.sv
module stop_capture_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              stop_in,
  input  logic              host_rd_en,
  input  logic              host_clr,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              host_rd_valid,
  output logic              status_ready,
  output logic [FILL_W-1:0] fill_level
);

  logic              stop_rise;
  logic              mem_we;
  logic              mem_re;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;

  stop_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (stop_in),
    .rise     (stop_rise)
  );

  ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .stop_rise  (stop_rise),
    .host_rd_en (host_rd_en),
    .host_clr   (host_clr),
    .mem_we     (mem_we),
    .wr_ptr     (wr_ptr),
    .mem_re     (mem_re),
    .rd_ptr     (rd_ptr),
    .frozen     (status_ready),
    .fill       (fill_level),
    .rd_valid   (host_rd_valid)
  );

  ring_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_ptr),
    .wdata (in_data),
    .re    (mem_re),
    .raddr (rd_ptr),
    .rdata (host_rd_data)
  );

endmodule

// File: rtl/stop_capture_ring_chk.sv
module stop_capture_ring_chk #(
  parameter int DEPTH = 2048,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              host_rd_en,
  input logic              host_clr,
  input logic              host_rd_valid,
  input logic              status_ready,
  input logic [FILL_W-1:0] fill_level,
  input logic              mem_we
);

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fill_level <= FILL_W'(DEPTH));

  p_no_write_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    status_ready |-> !mem_we);

  p_fill_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (status_ready && !host_clr) |=> $stable(fill_level));

  p_ready_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (status_ready && !host_clr) |=> status_ready);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    host_clr |=> (!status_ready && fill_level == '0));

  p_rd_armed_r7: assert property (@(posedge clk) disable iff (rst)
    (!status_ready && !host_rd_valid) |=> !host_rd_valid);

  p_rd_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (status_ready && host_rd_en) |=> host_rd_valid);

  p_fill_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!status_ready && !host_clr && in_valid && fill_level < FILL_W'(DEPTH))
      |=> (fill_level == $past(fill_level) + 1'b1 || status_ready));

endmodule

bind stop_capture_ring stop_capture_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .host_rd_en    (host_rd_en),
  .host_clr      (host_clr),
  .host_rd_valid (host_rd_valid),
  .status_ready  (status_ready),
  .fill_level    (fill_level),
  .mem_we        (mem_we)
);

// File: tb/sim_stop_capture_ring.sv
module sim_stop_capture_ring;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 2048;
  localparam int DATA_W = 16;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              stop_in = 1'b0;
  logic              host_rd_en = 1'b0;
  logic              host_clr = 1'b0;
  logic [DATA_W-1:0] host_rd_data;
  logic              host_rd_valid;
  logic              status_ready;
  logic [FILL_W-1:0] fill_level;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [DATA_W-1:0] hist [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_capture_ring u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .stop_in(stop_in), .host_rd_en(host_rd_en), .host_clr(host_clr),
    .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
    .status_ready(status_ready), .fill_level(fill_level)
  );

  function automatic int exp_fill(input int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // feed n cycles of gapped random words; stored tracks armed state
  task automatic feed(input int n, input bit stored);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      in_data  = DATA_W'($urandom);
      if (in_valid && stored) begin
        hist.push_back(in_data);
        if (hist.size() > DEPTH) void'(hist.pop_front());
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic feed_exact(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DATA_W'($urandom);
      hist.push_back(in_data);
      if (hist.size() > DEPTH) void'(hist.pop_front());
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    stop_in = 1'b1;
    repeat (4) @(negedge clk);
    stop_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    hist.delete();
  endtask

  task automatic read_word(input string req, input int exp);
    @(negedge clk);
    host_rd_en = 1'b1;
    @(negedge clk);
    host_rd_en = 1'b0;
    check(host_rd_valid === 1'b1, req, int'(host_rd_valid), 1);
    check(host_rd_data === DATA_W'(exp), req, int'(host_rd_data), exp);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status_ready === 1'b0, "R1", int'(status_ready), 0);
    check(fill_level === '0, "R1", int'(fill_level), 0);
    check(host_rd_valid === 1'b0, "R1", int'(host_rd_valid), 0);

    // R7 read while armed ignored
    @(negedge clk); host_rd_en = 1'b1;
    @(negedge clk); host_rd_en = 1'b0;
    check(host_rd_valid === 1'b0, "R7", int'(host_rd_valid), 0);

    // partial fill
    feed(150, 1'b1);
    check(fill_level == FILL_W'(exp_fill(hist.size())), "R2 partial", int'(fill_level), hist.size());
    // R3 timing: ready rises exactly at the third edge
    @(negedge clk); stop_in = 1'b1;
    @(negedge clk); check(status_ready === 1'b0, "R3 sync", int'(status_ready), 0);
    @(negedge clk); check(status_ready === 1'b0, "R3 sync", int'(status_ready), 0);
    @(negedge clk); check(status_ready === 1'b1, "R3 edge", int'(status_ready), 1);
    stop_in = 1'b0;
    repeat (3) @(negedge clk);
    // R4 words ignored while frozen
    feed(40, 1'b0);
    check(fill_level == FILL_W'(hist.size()), "R4 fill", int'(fill_level), hist.size());
    for (int k = 0; k < hist.size(); k++)
      read_word(k == 0 ? "R5 partial first" : "R6 partial", int'(hist[k]));

    // R8 clear
    clear();
    @(negedge clk);
    check(status_ready === 1'b0, "R8 ready", int'(status_ready), 0);
    check(fill_level === '0, "R8 fill", int'(fill_level), 0);

    // wrapped ring
    feed(DEPTH * 2 + 300, 1'b1);
    stop_pulse();
    check(fill_level == FILL_W'(DEPTH), "R2 full", int'(fill_level), DEPTH);
    for (int k = 0; k < 5; k++)
      read_word(k == 0 ? "R5 wrapped first" : "R6 wrapped", int'(hist[k]));
    // R9 second stop edge while frozen has no effect
    stop_pulse();
    check(status_ready === 1'b1, "R9 ready", int'(status_ready), 1);
    for (int k = 5; k < DEPTH; k++)
      read_word(k == 5 ? "R9 continue" : "R6 wrapped", int'(hist[k]));
    read_word("R6 pointer wrap", int'(hist[0]));

    // R3 level held across clear does not re-freeze
    @(negedge clk); stop_in = 1'b1;
    repeat (3) @(negedge clk);
    clear();
    feed(60, 1'b1);
    check(status_ready === 1'b0, "R3 level", int'(status_ready), 0);
    @(negedge clk); stop_in = 1'b0;
    repeat (3) @(negedge clk);
    stop_pulse();
    check(status_ready === 1'b1, "R3 new edge", int'(status_ready), 1);
    check(fill_level == FILL_W'(hist.size()), "R8 fresh fill", int'(fill_level), hist.size());
    read_word("R8 fresh first", int'(hist[0]));

    // empty capture
    clear();
    stop_pulse();
    check(status_ready === 1'b1, "R3 empty", int'(status_ready), 1);
    check(fill_level === '0, "R2 empty", int'(fill_level), 0);

    // exactly full ring
    clear();
    feed_exact(DEPTH);
    stop_pulse();
    check(fill_level == FILL_W'(DEPTH), "R2 exact", int'(fill_level), DEPTH);
    read_word("R5 exact first", int'(hist[0]));
    read_word("R6 exact second", int'(hist[1]));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule